// File: doc/BRIEF.md
# Flag-Producing 16-bit ALU

A purely combinational arithmetic and logic unit for a small 16-bit datapath. It takes two operands, a carry input and a five-bit operation select. It returns a 16-bit result and a 16-bit status word that can be written straight into a status register. The low two select bits pick one of four operation groups: arithmetic, logic, right shift, and left shift with byte swap. The next two select bits pick the operation inside that group.

The status word normally carries the carry, zero, negative and overflow flags in its four low bits, and it copies result bits 13 to 8. When the top select bit is set, the flag logic is bypassed. Result bits 13:8 and 3:0 then reach the status word unchanged, so software can load the flag and mode fields directly from a computed value. Subtraction always computes the second operand minus the first. The carry after subtraction is a borrow. The overflow value is defined for every operation, so it is repeatable from one run to the next.

Top module: `flag_alu16`

## Requirements
- R1: `sel[1:0]` selects the group: 0 arithmetic, 1 logic, 2 right shift, 3 left shift/swap. `sel[3:2]` selects the operation within the group. `sel[4]` selects the status mode.
- R2: Arithmetic code 0 gives `op_x + op_y` and code 2 gives `op_x + op_y + carry_in`. In both cases the carry is the unsigned carry out of bit 15.
- R3: Arithmetic code 1 gives `op_y - op_x` and code 3 gives `op_y - op_x - carry_in`. In both cases the carry is 1 exactly when the unsigned `op_y` is less than `op_x` plus the subtracted carry (a borrow).
- R4: In the arithmetic group, the overflow flag is the two's-complement signed overflow of the operation performed. In every other group, it is the overflow that the arithmetic operation with the same `sel[3:2]` code would produce on the same inputs.
- R5: Logic codes 0, 1, 2 and 3 give NOR, AND, XOR and OR of the operands. The carry is 0.
- R6: Right-shift codes shift `op_x` right by one. The bit entering bit 15 is `op_x[0]` for code 0 (rotate), `carry_in` for code 1, `op_x[15]` for code 2 (arithmetic) and 0 for code 3 (logical). The carry is `op_x[0]`.
- R7: Left-shift codes 0, 1 and 2 shift `op_x` left by one. The bit entering bit 0 is `op_x[15]` for code 0, `carry_in` for code 1 and 0 for code 2. The carry is `op_x[15]`.
- R8: Left-group code 3 is a byte swap. `result[7:0] = op_x[15:8]`, `result[15:8] = op_y[7:0]`, and the carry is `op_x[15]`.
- R9: The zero flag is 1 exactly when all 16 result bits are 0. The negative flag equals `result[15]`.
- R10: With `sel[4]=0`, `status_out[0]` is carry, `[1]` is zero, `[2]` is negative, `[3]` is overflow and `[13:8]` equals `result[13:8]`. Bits 15:14 and 7:4 are 0.
- R11: With `sel[4]=1`, `status_out[13:8]` and `[3:0]` equal the same result bits. All other status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 16 | First operand (subtrahend; shift and swap source) |
| op_y | input | 16 | Second operand (minuend; swap high-byte source) |
| carry_in | input | 1 | Carry input for carry-using operations |
| sel | input | 5 | [1:0] group, [3:2] operation, [4] status pass-through |
| result | output | 16 | Operation result |
| status_out | output | 16 | Flag word, or masked copy of the result |

## Verification
The bench drives the operand order of subtraction and checks the sign of the borrow. A design that computes `op_x - op_y`, or that reports a normal carry instead of a borrow, fails the subtract vectors. It checks that a logic XOR of two negative operands yields carry 0 even though the adder would carry out. It also checks the fill bit of each shift and the byte halves of the swap, where a swapped half or a wrong fill source changes the result. Overflow is checked in the non-arithmetic groups, and the bits outside the status fields are checked to be 0 in both status modes.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int DATA_W   = 16;
  localparam int SEL_W    = 5;
  localparam int HALF_W   = DATA_W / 2;
  localparam int FLAG_N   = 4;
  localparam int MID_LO   = 8;
  localparam int MID_HI   = 13;
  localparam int MID_W    = MID_HI - MID_LO + 1;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_SHR   = 2'd2,
    GRP_SHL   = 2'd3
  } grp_e;

  typedef struct packed {
    word_t sum;
    logic  carry;
    logic  ovf;
  } add_out_t;

  // Adder for y +/- x (+/- c); sub variants report borrow in carry.
  function automatic add_out_t add_core(input word_t x, input word_t y,
                                        input logic cin, input logic use_c,
                                        input logic inv);
    add_out_t   o;
    word_t      b;
    logic       ci;
    logic [DATA_W:0] wide;
    b    = inv ? ~x : x;
    ci   = use_c ? cin : 1'b0;
    ci   = inv ? ~ci : ci;
    wide = {1'b0, y} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
    o.sum   = wide[DATA_W-1:0];
    o.carry = inv ? ~wide[DATA_W] : wide[DATA_W];
    o.ovf   = (y[DATA_W-1] == b[DATA_W-1]) && (wide[DATA_W-1] != y[DATA_W-1]);
    return o;
  endfunction
endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
  import flag_alu_pkg::*;
(
  input  word_t      op_x,
  input  word_t      op_y,
  input  logic       carry_in,
  input  logic [1:0] op,
  output word_t      sum,
  output logic       carry,
  output logic       ovf
);
  add_out_t res;

  always_comb begin
    res   = add_core(op_x, op_y, carry_in, op[1], op[0]);
    sum   = res.sum;
    carry = res.carry;
    ovf   = res.ovf;
  end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
(
  input  word_t      op_x,
  input  word_t      op_y,
  input  logic [1:0] op,
  output word_t      res
);
  always_comb begin
    unique case (op)
      2'd0:    res = ~(op_x | op_y);
      2'd1:    res = op_x & op_y;
      2'd2:    res = op_x ^ op_y;
      default: res = op_x | op_y;
    endcase
  end
endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift
  import flag_alu_pkg::*;
#(
  parameter bit TO_LEFT = 1'b0
) (
  input  word_t      op_x,
  input  logic       carry_in,
  input  logic [1:0] op,
  output word_t      res,
  output logic       carry
);
  logic fill;

  generate
    if (TO_LEFT) begin : g_left
      always_comb begin
        unique case (op)
          2'd0:    fill = op_x[DATA_W-1];
          2'd1:    fill = carry_in;
          default: fill = 1'b0;
        endcase
        res   = {op_x[DATA_W-2:0], fill};
        carry = op_x[DATA_W-1];
      end
    end else begin : g_right
      always_comb begin
        unique case (op)
          2'd0:    fill = op_x[0];
          2'd1:    fill = carry_in;
          2'd2:    fill = op_x[DATA_W-1];
          default: fill = 1'b0;
        endcase
        res   = {fill, op_x[DATA_W-1:1]};
        carry = op_x[0];
      end
    end
  endgenerate
endmodule

// File: rtl/flag_alu_status.sv
module flag_alu_status
  import flag_alu_pkg::*;
(
  input  logic              pass_mode,
  input  logic [MID_W-1:0]  mid_bits,
  input  logic [FLAG_N-1:0] low_bits,
  input  logic              carry_f,
  input  logic              zero_f,
  input  logic              neg_f,
  input  logic              ovf_f,
  output word_t             status
);
  always_comb begin
    status                = '0;
    status[MID_HI:MID_LO] = mid_bits;
    if (pass_mode) status[FLAG_N-1:0] = low_bits;
    else           status[FLAG_N-1:0] = {ovf_f, neg_f, zero_f, carry_f};
  end
endmodule

// File: rtl/flag_alu16.sv
module flag_alu16
  import flag_alu_pkg::*;
(
  input  logic [DATA_W-1:0] op_x,
  input  logic [DATA_W-1:0] op_y,
  input  logic              carry_in,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] status_out
);
  grp_e  grp;
  word_t arith_res, logic_res, shr_res, shl_res, swap_res;
  logic  arith_c, shr_c, shl_c;
  logic  carry_flag, ovf_flag, zero_flag, neg_flag;

  assign grp = grp_e'(sel[1:0]);

  flag_alu_arith u_arith (
    .op_x(op_x), .op_y(op_y), .carry_in(carry_in), .op(sel[3:2]),
    .sum(arith_res), .carry(arith_c), .ovf(ovf_flag)
  );

  flag_alu_logic u_logic (
    .op_x(op_x), .op_y(op_y), .op(sel[3:2]), .res(logic_res)
  );

  flag_alu_shift #(.TO_LEFT(1'b0)) u_shr (
    .op_x(op_x), .carry_in(carry_in), .op(sel[3:2]),
    .res(shr_res), .carry(shr_c)
  );

  flag_alu_shift #(.TO_LEFT(1'b1)) u_shl (
    .op_x(op_x), .carry_in(carry_in), .op(sel[3:2]),
    .res(shl_res), .carry(shl_c)
  );

  assign swap_res = {op_y[HALF_W-1:0], op_x[DATA_W-1:HALF_W]};

  always_comb begin
    unique case (grp)
      GRP_ARITH: begin result = arith_res; carry_flag = arith_c; end
      GRP_LOGIC: begin result = logic_res; carry_flag = 1'b0;    end
      GRP_SHR:   begin result = shr_res;   carry_flag = shr_c;   end
      default: begin
        result     = (sel[3:2] == 2'd3) ? swap_res : shl_res;
        carry_flag = shl_c;
      end
    endcase
  end

  assign zero_flag = ~|result;
  assign neg_flag  = result[DATA_W-1];

  flag_alu_status u_status (
    .pass_mode(sel[4]),
    .mid_bits(result[MID_HI:MID_LO]),
    .low_bits(result[FLAG_N-1:0]),
    .carry_f(carry_flag), .zero_f(zero_flag),
    .neg_f(neg_flag), .ovf_f(ovf_flag),
    .status(status_out)
  );
endmodule

// File: rtl/flag_alu16_chk.sv
module flag_alu16_chk
  import flag_alu_pkg::*;
(
  input logic [DATA_W-1:0] op_x,
  input logic [SEL_W-1:0]  sel,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] status_out,
  input logic              carry_flag,
  input logic              ovf_flag
);
  always_comb begin
    // R10
    status_pack_chk: assert (sel[4] || (status_out[15:14] == 2'b00 &&
                             status_out[7:4] == 4'h0 &&
                             status_out[MID_HI:MID_LO] == result[MID_HI:MID_LO]))
      else $error("status packing");
    // R9
    zero_flag_chk: assert (sel[4] || (status_out[1] == (result == '0)))
      else $error("zero flag");
    // R9
    neg_flag_chk: assert (sel[4] || (status_out[2] == result[DATA_W-1]))
      else $error("negative flag");
    // R10
    carry_out_chk: assert (sel[4] || (status_out[0] == carry_flag))
      else $error("carry placement");
    // R4
    ovf_out_chk: assert (sel[4] || (status_out[3] == ovf_flag))
      else $error("overflow placement");
    // R11
    pass_through_chk: assert (!sel[4] || (status_out[3:0] == result[3:0] &&
                              status_out[MID_HI:MID_LO] == result[MID_HI:MID_LO] &&
                              status_out[7:4] == 4'h0 && status_out[15:14] == 2'b00))
      else $error("pass-through");
    // R5
    logic_carry_chk: assert (sel[1:0] != 2'd1 || !carry_flag)
      else $error("logic carry");
    // R6
    shr_carry_chk: assert (sel[1:0] != 2'd2 || carry_flag == op_x[0])
      else $error("right shift carry");
    // R7
    shl_carry_chk: assert (sel[1:0] != 2'd3 || carry_flag == op_x[DATA_W-1])
      else $error("left shift carry");
  end
endmodule

bind flag_alu16 flag_alu16_chk u_chk (
  .op_x(op_x), .sel(sel), .result(result), .status_out(status_out),
  .carry_flag(carry_flag), .ovf_flag(ovf_flag)
);

// File: tb/flag_alu16_tb.sv
module flag_alu16_tb;
  logic        clk = 1'b0;
  logic [15:0] op_x = '0, op_y = '0;
  logic        carry_in = 1'b0;
  logic [4:0]  sel = '0;
  logic [15:0] result, status_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5ns clk = ~clk;

  flag_alu16 u_dut (.op_x(op_x), .op_y(op_y), .carry_in(carry_in), .sel(sel),
                    .result(result), .status_out(status_out));

  // {sel, cin, x, y, expected result, expected status}
  localparam int NV = 15;
  localparam logic [69:0] VEC [NV] = '{
    {5'b00000, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 16'h000C},
    {5'b00100, 1'b0, 16'h0001, 16'h0000, 16'hFFFF, 16'h3F05},
    {5'b01000, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 16'h0003},
    {5'b01100, 1'b0, 16'h0001, 16'h8000, 16'h7FFF, 16'h3F08},
    {5'b00001, 1'b0, 16'h0F0F, 16'h00FF, 16'hF000, 16'h3004},
    {5'b10101, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h3F0F},
    {5'b00010, 1'b0, 16'h0001, 16'h0000, 16'h8000, 16'h0005},
    {5'b00110, 1'b1, 16'h0002, 16'h0000, 16'h8001, 16'h0004},
    {5'b01010, 1'b0, 16'h8002, 16'h0000, 16'hC001, 16'h0004},
    {5'b01110, 1'b0, 16'h8001, 16'h0000, 16'h4000, 16'h0001},
    {5'b00011, 1'b0, 16'h8000, 16'h0000, 16'h0001, 16'h0001},
    {5'b00111, 1'b1, 16'h4000, 16'h0000, 16'h8001, 16'h0004},
    {5'b01011, 1'b1, 16'h8000, 16'h0000, 16'h0000, 16'h0003},
    {5'b01111, 1'b0, 16'hAB12, 16'h34CD, 16'hCDAB, 16'h0D0D},
    {5'b01001, 1'b0, 16'h8000, 16'h8000, 16'h0000, 16'h000A}
  };

  function automatic string req_tag(input logic [4:0] s);
    if (s[4]) return "R11";
    case (s[1:0])
      2'd0:    return s[2] ? "R3" : "R2";
      2'd1:    return "R5";
      2'd2:    return "R6";
      default: return (s[3:2] == 2'd3) ? "R8" : "R7";
    endcase
  endfunction

  // Independent restatement with integer arithmetic: {result, status}
  function automatic logic [31:0] ref_calc(input logic [4:0] s, input logic [15:0] x,
                                           input logic [15:0] y, input logic c);
    int ux, uy, sx, sy, ci, u, sv;
    logic cf, vf, ac;
    logic [15:0] z, ar, st;
    ux = int'(x); uy = int'(y);
    sx = int'($signed(x)); sy = int'($signed(y));
    ci = s[3] ? int'(c) : 0;
    if (!s[2]) begin u = ux + uy + ci; sv = sx + sy + ci; ac = (u > 65535); end
    else       begin u = uy - ux - ci; sv = sy - sx - ci; ac = (u < 0);     end
    ar = u[15:0];
    vf = (sv > 32767) || (sv < -32768);
    case (s[1:0])
      2'd0: begin z = ar; cf = ac; end
      2'd1: begin
        case (s[3:2])
          2'd0: z = ~(x | y);
          2'd1: z = x & y;
          2'd2: z = x ^ y;
          default: z = x | y;
        endcase
        cf = 1'b0;
      end
      2'd2: begin
        z = x >> 1;
        case (s[3:2])
          2'd0: z[15] = x[0];
          2'd1: z[15] = c;
          2'd2: z[15] = x[15];
          default: z[15] = 1'b0;
        endcase
        cf = x[0];
      end
      default: begin
        z = x << 1;
        case (s[3:2])
          2'd0: z[0] = x[15];
          2'd1: z[0] = c;
          2'd2: z[0] = 1'b0;
          default: z = {y[7:0], x[15:8]};
        endcase
        cf = x[15];
      end
    endcase
    st = 16'h0000;
    st[13:8] = z[13:8];
    if (s[4]) st[3:0] = z[3:0];
    else      st[3:0] = {vf, z[15], (z == 16'h0000), cf};
    return {z, st};
  endfunction

  task automatic apply(input logic [4:0] s, input logic c, input logic [15:0] x,
                       input logic [15:0] y);
    @(negedge clk);
    sel = s; carry_in = c; op_x = x; op_y = y;
    #1ns;
  endtask

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h (sel=%b x=%h y=%h cin=%b)",
               tag, act, exp, sel, op_x, op_y, carry_in);
    end
  endtask

  initial begin
    #2ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    // Idle state: all-zero inputs give add 0+0 -> zero flag only (R9, R10)
    apply(5'b00000, 1'b0, 16'h0000, 16'h0000);
    check16("R9 idle result", result, 16'h0000);
    check16("R10 idle status", status_out, 16'h0002);

    // Hand-computed vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][69:65], VEC[i][64], VEC[i][63:48], VEC[i][47:32]);
      check16(req_tag(VEC[i][69:65]), result, VEC[i][31:16]);
      check16("R4 R9 R10 status", status_out, VEC[i][15:0]);
    end

    // Sweep every select code against the bench model (R1, R4)
    for (int p = 0; p < 6; p++) begin
      logic [15:0] xs, ys;
      case (p)
        0: begin xs = 16'h0000; ys = 16'hFFFF; end
        1: begin xs = 16'h8000; ys = 16'h7FFF; end
        2: begin xs = 16'h1234; ys = 16'h1234; end
        3: begin xs = 16'hFFFF; ys = 16'h0001; end
        4: begin xs = 16'hA5C3; ys = 16'h5A3C; end
        default: begin xs = 16'h7FFF; ys = 16'h8000; end
      endcase
      for (int s = 0; s < 32; s++) begin
        for (int c = 0; c < 2; c++) begin
          apply(5'(s), 1'(c), xs, ys);
          r = ref_calc(5'(s), xs, ys, 1'(c));
          check16({"R1 sweep ", req_tag(5'(s))}, result, r[31:16]);
          check16("R4 sweep status", status_out, r[15:0]);
        end
      end
    end

    // Borrow boundary: equal operands with carry give borrow (R3)
    apply(5'b01100, 1'b1, 16'h0005, 16'h0005);
    check16("R3 borrow edge", {result[15:0]}, 16'hFFFF);
    check16("R3 borrow flag", {15'h0, status_out[0]}, 16'h0001);
    apply(5'b01100, 1'b0, 16'h0005, 16'h0005);
    check16("R3 no borrow flag", {15'h0, status_out[0]}, 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule